// File: doc/BRIEF.md
# Voice Sequencer Instruction Controller

This block steps a speech or sound playback engine through its voice groups by running a short program. It fetches 16-bit instruction words from an external program ROM and holds four 8-bit general registers. It writes six 8-bit control outputs: two enable values, two mode values, a stop value and a page value. The instruction set covers immediate and register-indirect jumps, immediate loads, register copies, increments and a stop instruction. Any instruction can be made conditional. A condition tests either the playback-finished status or the level of one of three trigger inputs.

Instructions are paced by a one-cycle `tick` pulse at the sample rate. Each instruction uses exactly two ticks: the word is fetched on the first tick and executed on the second. A sequence is started in one of two ways. A `go` pulse starts it at any entry address. A rising edge on a trigger input starts it at the entry point equal to that trigger's index, but only when the block is idle and not in processor-driven mode. In processor-driven mode, a falling edge on trigger 0 halts execution. Loading the page value while mode-0 bit 0 is set emits a playback-start pulse. A `play_done` input reports the end of playback back to the controller.

Top module: `vseq_ctrl`

## Requirements
- R1: After reset, all six control outputs, `rom_addr`, `running` and `start_play` are 0, and the playback-finished status is clear.
- R2: The instruction word is {op[15:12], cond_en[11], cond_sel[10:8], arg[7:0]}. While running, the first tick latches `rom_data` at `rom_addr`, and the next tick executes that word. Control outputs change only in the cycle after an executing tick.
- R3: Opcodes 2 to 5 load `arg` into general registers R0 to R3. Opcodes 6 to 11 load `arg` into en0, en1, mode0, mode1, stop_val and page_val respectively.
- R4: Opcode 12 copies R[arg[1:0]] into R[arg[3:2]]. Opcode 13 adds one to R[arg[1:0]] and wraps from 8'hFF to 8'h00.
- R5: Opcode 0 jumps to `arg`. Opcode 1 jumps to the value held in R[arg[1:0]]. Opcode 15 does nothing.
- R6: When cond_en is 1, the instruction takes effect only if its condition is true; otherwise it has no effect and the PC advances by one. cond_sel 0 tests finished, and 4 tests not finished. Values 1 to 3 test trigger (sel-1) high, and 5 to 7 test trigger (sel-5) low.
- R7: Opcode 14 (end) clears `running` and leaves `rom_addr` on the end instruction's address. The PC wraps from 255 to 0.
- R8: A `go` pulse starts execution at `go_addr` from the fetch step, including while already running.
- R9: Triggers pass through two synchronizing flops. When the block is idle and `cpu_mode` is 0, a rising edge on trigger i starts execution at address i. When `cpu_mode` is 1, such edges are ignored.
- R10: When `cpu_mode` is 1 and the block is running, a falling edge on trigger 0 clears `running` and holds `rom_addr`. When `cpu_mode` is 0, that edge does not halt execution.
- R11: Executing a page load while mode0 bit 0 is set gives a one-cycle `start_play` pulse. The mode0 value used is the one held before that instruction. With bit 0 clear, there is no pulse.
- R12: A `play_done` pulse sets the finished status, and a `start_play` pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-rate step pulse |
| go | input | 1 | Start request |
| go_addr | input | 8 | Start address for `go` |
| cpu_mode | input | 1 | Processor-driven mode select |
| trig_in | input | 3 | Asynchronous trigger inputs |
| play_done | input | 1 | Playback finished pulse |
| rom_addr | output | 8 | Program address (current PC) |
| rom_data | input | 16 | Instruction word at `rom_addr` |
| en0 | output | 8 | Enable value 0 |
| en1 | output | 8 | Enable value 1 |
| mode0 | output | 8 | Mode value 0 |
| mode1 | output | 8 | Mode value 1 |
| stop_val | output | 8 | Stop value |
| page_val | output | 8 | Page value |
| start_play | output | 1 | Playback start pulse |
| running | output | 1 | Sequencer executing |

## Verification
The general registers have no port of their own, so their contents are the hardest state to observe. The bench brings each value out by ending a short program with a register-indirect jump onto an end instruction; the stopped `rom_addr` then equals the register value. A sweep over almost every byte value uses this path to test load plus increment, including the wrap to zero. The finished status is also internal. It is reached by a playback-start and `play_done` handshake, and every condition code is then swept over all trigger patterns with the status both clear and set.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int NTRIG = 3;
  localparam int NCTL  = 6;

  typedef enum logic [3:0] {
    OP_JPI  = 4'd0,
    OP_JPR  = 4'd1,
    OP_LD0  = 4'd2,
    OP_LD1  = 4'd3,
    OP_LD2  = 4'd4,
    OP_LD3  = 4'd5,
    OP_EN0  = 4'd6,
    OP_EN1  = 4'd7,
    OP_MD0  = 4'd8,
    OP_MD1  = 4'd9,
    OP_STP  = 4'd10,
    OP_PAGE = 4'd11,
    OP_MV   = 4'd12,
    OP_INC  = 4'd13,
    OP_END  = 4'd14,
    OP_NOP  = 4'd15
  } op_e;
endpackage

// File: rtl/vseq_trig_sync.sv
module vseq_trig_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1, s2, s3;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        s1[g] <= 1'b0;
        s2[g] <= 1'b0;
        s3[g] <= 1'b0;
      end else begin
        s1[g] <= din[g];
        s2[g] <= s1[g];
        s3[g] <= s2[g];
      end
    end
    assign lvl[g]  = s2[g];
    assign rise[g] = s2[g] & ~s3[g];
    assign fall[g] = ~s2[g] & s3[g];
  end
endmodule

// File: rtl/vseq_cond.sv
module vseq_cond import vseq_pkg::*; (
  input  logic [2:0]       sel,
  input  logic             last,
  input  logic [NTRIG-1:0] lvl,
  output logic             ok
);
  logic base;
  always_comb begin
    if (sel[1:0] == 2'd0) base = last;
    else                  base = lvl[2'(sel[1:0] - 2'd1)];
    ok = base ^ sel[2];
  end
endmodule

// File: rtl/vseq_regfile.sv
module vseq_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RIW-1:0] wa,
  input  logic [DW-1:0]  wd,
  input  logic [RIW-1:0] ra,
  output logic [DW-1:0]  rd
);
  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                      mem[g] <= '0;
      else if (we && wa == RIW'(g)) mem[g] <= wd;
    end
  end

  assign rd = mem[ra];
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl import vseq_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int NREG   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  go,
  input  logic [ADDR_W-1:0]     go_addr,
  input  logic                  cpu_mode,
  input  logic [NTRIG-1:0]      trig_in,
  input  logic                  play_done,
  output logic [ADDR_W-1:0]     rom_addr,
  input  logic [DATA_W+7:0]     rom_data,
  output logic [DATA_W-1:0]     en0,
  output logic [DATA_W-1:0]     en1,
  output logic [DATA_W-1:0]     mode0,
  output logic [DATA_W-1:0]     mode1,
  output logic [DATA_W-1:0]     stop_val,
  output logic [DATA_W-1:0]     page_val,
  output logic                  start_play,
  output logic                  running
);
  localparam int IW  = DATA_W + 8;
  localparam int RIW = $clog2(NREG);
  localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] pc;
  logic              phase;
  logic              run_q;
  logic              last_q;
  logic              sp_q;
  logic [IW-1:0]     ir;
  logic [DATA_W-1:0] ctl [NCTL];

  op_e               op;
  logic              cnd;
  logic [2:0]        csel;
  logic [DATA_W-1:0] arg;

  assign op   = op_e'(ir[IW-1 -: 4]);
  assign cnd  = ir[DATA_W+3];
  assign csel = ir[DATA_W+2 -: 3];
  assign arg  = ir[DATA_W-1:0];

  // trigger synchronizer and edge detect
  logic [NTRIG-1:0] trg_lvl, trg_rise, trg_fall;
  vseq_trig_sync #(.N(NTRIG)) u_sync (
    .clk(clk), .rst(rst), .din(trig_in),
    .lvl(trg_lvl), .rise(trg_rise), .fall(trg_fall)
  );

  // condition evaluation
  logic cond_ok;
  vseq_cond u_cond (.sel(csel), .last(last_q), .lvl(trg_lvl), .ok(cond_ok));

  // step qualification
  logic halt_now, trig_start, step, fetch, take;
  logic [ADDR_W-1:0] trig_entry;

  assign halt_now   = run_q && cpu_mode && trg_fall[0];
  assign trig_start = !run_q && !cpu_mode && (|trg_rise);
  assign step       = !go && !halt_now && run_q && tick;
  assign fetch      = step && !phase;
  assign take       = step && phase && (!cnd || cond_ok);

  always_comb begin
    trig_entry = '0;
    for (int i = NTRIG - 1; i >= 0; i--) begin
      if (trg_rise[i]) trig_entry = ADDR_W'(i);
    end
  end

  // general registers
  logic           rf_we;
  logic [RIW-1:0] rf_wa;
  logic [DATA_W-1:0] rf_wd, rf_rd;

  vseq_regfile #(.DW(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .ra(arg[RIW-1:0]), .rd(rf_rd)
  );

  always_comb begin
    rf_we = 1'b0;
    rf_wa = arg[RIW-1:0];
    rf_wd = arg;
    if (take) begin
      unique case (op)
        OP_LD0, OP_LD1, OP_LD2, OP_LD3: begin
          rf_we = 1'b1;
          rf_wa = RIW'(int'(op) - int'(OP_LD0));
        end
        OP_MV: begin
          rf_we = 1'b1;
          rf_wa = arg[2*RIW-1:RIW];
          rf_wd = rf_rd;
        end
        OP_INC: begin
          rf_we = 1'b1;
          rf_wd = rf_rd + DATA_W'(1);
        end
        default: ;
      endcase
    end
  end

  // control value registers
  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst)                                    ctl[g] <= '0;
      else if (take && int'(op) == int'(OP_EN0) + g) ctl[g] <= arg;
    end
  end

  assign en0      = ctl[0];
  assign en1      = ctl[1];
  assign mode0    = ctl[2];
  assign mode1    = ctl[3];
  assign stop_val = ctl[4];
  assign page_val = ctl[5];

  // playback handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      sp_q <= take && (op == OP_PAGE) && ctl[2][0];
      if (sp_q)           last_q <= 1'b0;
      else if (play_done) last_q <= 1'b1;
    end
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      phase <= 1'b0;
      run_q <= 1'b0;
      ir    <= '0;
    end else if (go) begin
      pc    <= go_addr;
      phase <= 1'b0;
      run_q <= 1'b1;
    end else if (halt_now) begin
      run_q <= 1'b0;
      phase <= 1'b0;
    end else if (trig_start) begin
      pc    <= trig_entry;
      phase <= 1'b0;
      run_q <= 1'b1;
    end else if (fetch) begin
      ir    <= rom_data;
      phase <= 1'b1;
    end else if (step) begin
      phase <= 1'b0;
      if (take) begin
        unique case (op)
          OP_JPI:  pc <= arg[ADDR_W-1:0];
          OP_JPR:  pc <= rf_rd[ADDR_W-1:0];
          OP_END:  run_q <= 1'b0;
          default: pc <= pc + PC_ONE;
        endcase
      end else begin
        pc <= pc + PC_ONE;
      end
    end
  end

  assign rom_addr   = pc;
  assign running    = run_q;
  assign start_play = sp_q;
endmodule

// File: rtl/vseq_ctrl_chk.sv
module vseq_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int NT     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              go,
  input logic              cpu_mode,
  input logic              play_done,
  input logic              running,
  input logic              start_play,
  input logic [DATA_W-1:0] en0,
  input logic [DATA_W-1:0] page_val,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [NT-1:0]     sync_rise,
  input logic [NT-1:0]     sync_fall,
  input logic              last_flag
);
  // R11
  sp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    start_play |=> !start_play);

  // R10
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    (running && cpu_mode && sync_fall[0] && !go) |=> !running);

  // R2
  en0_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(en0) |-> $past(tick && running));

  // R2
  page_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(page_val) |-> $past(tick && running));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && !go && !(!cpu_mode && (|sync_rise))) |=> ($stable(rom_addr) && !running));

  // R12
  last_set_chk: assert property (@(posedge clk) disable iff (rst)
    (play_done && !start_play) |=> last_flag);
endmodule

bind vseq_ctrl vseq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NT(vseq_pkg::NTRIG)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .go(go), .cpu_mode(cpu_mode),
  .play_done(play_done), .running(running), .start_play(start_play),
  .en0(en0), .page_val(page_val), .rom_addr(rom_addr),
  .sync_rise(trg_rise), .sync_fall(trg_fall), .last_flag(last_q)
);

// File: tb/sim_vseq_ctrl.sv
module sim_vseq_ctrl;
  localparam int CLK_P = 10;
  localparam logic [3:0] JPI = 4'd0, JPR = 4'd1, LD0 = 4'd2, LD1 = 4'd3, LD2 = 4'd4,
                         EN0 = 4'd6, EN1 = 4'd7, MD0 = 4'd8, MD1 = 4'd9, STP = 4'd10,
                         PGE = 4'd11, MVR = 4'd12, INC = 4'd13, ENDI = 4'd14, NOP = 4'd15;

  logic clk = 0, rst = 1, tick = 0, go = 0, cpu_mode = 1, play_done = 0;
  logic [7:0] go_addr = 0;
  logic [2:0] trig_in = 0;
  logic [7:0] rom_addr, en0, en1, mode0, mode1, stop_val, page_val;
  logic [15:0] rom_data;
  logic start_play, running;
  logic [15:0] mem [256];
  int checks = 0, errors = 0, sp_cnt = 0, tcnt = 0;
  bit exp_last = 0;

  always #(CLK_P/2) clk = ~clk;
  assign rom_data = mem[rom_addr];

  vseq_ctrl u0 (
    .clk(clk), .rst(rst), .tick(tick), .go(go), .go_addr(go_addr),
    .cpu_mode(cpu_mode), .trig_in(trig_in), .play_done(play_done),
    .rom_addr(rom_addr), .rom_data(rom_data), .en0(en0), .en1(en1),
    .mode0(mode0), .mode1(mode1), .stop_val(stop_val), .page_val(page_val),
    .start_play(start_play), .running(running)
  );

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    tick = (tcnt == 0);
    if (start_play) sp_cnt++;
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic c,
                                      input logic [2:0] s, input logic [7:0] a);
    return {op, c, s, a};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic fill_end();
    for (int i = 0; i < 256; i++) mem[i] = ins(ENDI, 0, 0, 0);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_at(input logic [7:0] a);
    go = 1; go_addr = a;
    @(negedge clk);
    go = 0;
    for (int i = 0; i < 4000 && running; i++) @(negedge clk);
  endtask

  task automatic pulse_done();
    play_done = 1; @(negedge clk); play_done = 0;
  endtask

  task automatic cond_sweep();
    for (int p = 0; p < 8; p++) begin
      trig_in = 3'(p);
      cycles(5);
      for (int s = 0; s < 8; s++) begin
        bit base, ok;
        fill_end();
        mem[8'h40] = ins(JPI, 1, 3'(s), 8'h60);
        base = (s % 4 == 0) ? exp_last : trig_in[(s % 4) - 1];
        ok = base ^ (s >= 4);
        run_at(8'h40);
        // R6
        chk($sformatf("R6 sel=%0d trig=%0d last=%0d", s, p, exp_last),
            rom_addr, ok ? 8'h60 : 8'h41);
      end
    end
    trig_in = 0;
    cycles(5);
  endtask

  initial begin
    #(CLK_P * 180000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    fill_end();
    cycles(3);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 rom_addr", rom_addr, 0);
    chk("R1 running", running, 0);
    chk("R1 outputs", {en0, en1, mode0, mode1, stop_val, page_val}, 0);
    chk("R1 start_play", start_play, 0);

    // R3 control loads and R2 timing
    mem[8'h10] = ins(EN0, 0, 0, 8'h11);
    mem[8'h11] = ins(EN1, 0, 0, 8'h22);
    mem[8'h12] = ins(MD0, 0, 0, 8'h32);
    mem[8'h13] = ins(MD1, 0, 0, 8'h44);
    mem[8'h14] = ins(STP, 0, 0, 8'h55);
    mem[8'h15] = ins(PGE, 0, 0, 8'h66);
    go = 1; go_addr = 8'h10; @(negedge clk); go = 0;
    cycles(3);
    // R2: one tick has at most fetched, nothing executed yet
    chk("R2 no effect before execute tick", en0, 0);
    for (int i = 0; i < 4000 && running; i++) @(negedge clk);
    chk("R3 en0", en0, 8'h11);
    chk("R3 en1", en1, 8'h22);
    chk("R3 mode0", mode0, 8'h32);
    chk("R3 mode1", mode1, 8'h44);
    chk("R3 stop", stop_val, 8'h55);
    chk("R3 page", page_val, 8'h66);
    // R11: mode0 bit0 clear, no pulse
    chk("R11 no pulse", sp_cnt, 0);
    chk("R7 stop address", rom_addr, 8'h16);

    // R6 with finished status clear
    cond_sweep();

    // R4 load + increment sweep, observed by indirect jump (R5)
    for (int v = 0; v < 256; v++) begin
      if (v >= 8'h7F && v <= 8'h81) continue;
      fill_end();
      mem[8'h80] = ins(LD1, 0, 0, 8'(v));
      mem[8'h81] = ins(INC, 0, 0, 8'h01);
      mem[8'h82] = ins(JPR, 0, 0, 8'h01);
      run_at(8'h80);
      chk($sformatf("R4 inc v=%0h", v), rom_addr, (v + 1) % 256);
    end

    // R4 move, R5 immediate jump and nop
    for (int v = 8'h20; v < 8'h70; v += 8'h13) begin
      fill_end();
      mem[8'h80] = ins(LD0, 0, 0, 8'(v));
      mem[8'h81] = ins(NOP, 0, 0, 0);
      mem[8'h82] = ins(MVR, 0, 0, 8'b0000_1000);
      mem[8'h83] = ins(JPR, 0, 0, 8'h02);
      run_at(8'h80);
      chk($sformatf("R4 move v=%0h", v), rom_addr, v);
    end
    fill_end();
    mem[8'h05] = ins(JPI, 0, 0, 8'hC7);
    mem[8'hC7] = ins(LD2, 0, 0, 8'h00);
    run_at(8'h05);
    chk("R5 immediate jump", rom_addr, 8'hC8);

    // R7 wrap 255 -> 0
    fill_end();
    mem[8'hFE] = ins(EN1, 0, 0, 8'hA5);
    mem[8'hFF] = ins(STP, 0, 0, 8'h3C);
    run_at(8'hFE);
    chk("R7 wrap address", rom_addr, 0);
    chk("R7 wrap en1", en1, 8'hA5);
    chk("R7 wrap stop", stop_val, 8'h3C);

    // R11 / R12 playback handshake
    fill_end();
    mem[8'h90] = ins(MD0, 0, 0, 8'h01);
    mem[8'h91] = ins(PGE, 0, 0, 8'h09);
    mem[8'h92] = ins(JPI, 1, 3'd4, 8'h92);
    go = 1; go_addr = 8'h90; @(negedge clk); go = 0;
    cycles(60);
    chk("R11 pulse count", sp_cnt, 1);
    chk("R12 waits for done", running, 1);
    pulse_done();
    for (int i = 0; i < 4000 && running; i++) @(negedge clk);
    chk("R12 done releases loop", rom_addr, 8'h93);
    exp_last = 1;
    cond_sweep();
    // R12: new start clears finished status
    fill_end();
    mem[8'h30] = ins(PGE, 0, 0, 8'h0A);
    mem[8'h31] = ins(JPI, 1, 3'd0, 8'h50);
    run_at(8'h30);
    chk("R11 second pulse", sp_cnt, 2);
    chk("R12 cleared by start", rom_addr, 8'h32);
    exp_last = 0;

    // R10 halt in processor mode
    fill_end();
    cpu_mode = 1;
    trig_in = 3'b001;
    cycles(6);
    chk("R9 cpu mode ignores rise", running, 0);
    mem[8'hA0] = ins(JPI, 0, 0, 8'hA0);
    go = 1; go_addr = 8'hA0; @(negedge clk); go = 0;
    cycles(30);
    trig_in = 0;
    cycles(6);
    chk("R10 halted", running, 0);
    chk("R10 address held", rom_addr, 8'hA0);

    // R10 no halt outside processor mode, R8 go while running
    trig_in = 3'b001;
    cycles(6);
    go = 1; go_addr = 8'hA0; @(negedge clk); go = 0;
    cpu_mode = 0;
    cycles(4);
    trig_in = 0;
    cycles(10);
    chk("R10 no halt when cpu_mode=0", running, 1);
    go = 1; go_addr = 8'hB3; @(negedge clk); go = 0;
    cycles(20);
    chk("R8 restart while running", rom_addr, 8'hB3);
    chk("R8 stopped on end", running, 0);

    // R9 trigger start at entry
    mem[8'h01] = ins(EN0, 0, 0, 8'h5A);
    trig_in = 3'b010;
    cycles(8);
    chk("R9 trigger start", running, 1);
    for (int i = 0; i < 4000 && running; i++) @(negedge clk);
    chk("R9 entry en0", en0, 8'h5A);
    chk("R9 entry address", rom_addr, 8'h02);
    cpu_mode = 1;
    trig_in = 0;
    cycles(6);
    mem[8'h01] = ins(EN0, 0, 0, 8'h33);
    trig_in = 3'b010;
    cycles(30);
    chk("R9 ignored in cpu mode run", running, 0);
    chk("R9 ignored in cpu mode en0", en0, 8'h5A);
    trig_in = 0;
    cycles(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule